// File: doc/BRIEF.md
# ATM Cell Header Check Engine

This block sits on a 32-bit word stream that carries 53-byte ATM cells. Each cell takes 14 words. The first word, marked by a start-of-cell strobe, holds the four header bytes. The second word carries the header error control (HEC) byte in its top byte. The remaining twelve words carry the 48-byte payload. On receive, the engine holds the first header word until the HEC word arrives and then judges the cell. A cell whose HEC is wrong produces nothing on any output. A good cell goes to the application port when its connection identifier equals a configured value, and to the bypass port otherwise.

On transmit, cells coming from the application are passed to the line one cycle later. The top byte of their second word is overwritten with a freshly computed HEC. Ready indications from the downstream receivers are registered and passed back upstream. Words already inside the engine are never held back by a low ready.

Top module: `atm_cell_hec_engine`

## Requirements
- R1: While `rst_n` is low at a clock edge (synchronous, active low), the edge clears every valid, start and ready output to 0.
- R2: The receive HEC is a CRC-8 with generator x^8+x^2+x+1. It starts from zero, runs over header bytes [31:24], [23:16], [15:8] and [7:0] of word 0 (most significant bit first), and the result is XORed with 0x55. When this differs from word 1 bits [31:24], none of the cell's 14 words raise `app_vld_o` or `byp_vld_o`.
- R3: A cell that passes R2 goes to the application port when word 0 bits [27:4] equal `cfg_vc_i` (sampled in the cycle word 1 is accepted), and to the bypass port otherwise. The two valid outputs are never high together.
- R4: For a passing cell, word 0 leaves with its start strobe one edge after word 1 is accepted. Every later word leaves one edge after it is accepted. All 14 words leave unchanged, in order, including the received HEC word.
- R5: A receive word with `rx_vld_i` high and `rx_soc_i` low while no cell is open produces no output. This includes a 15th word after a complete cell.
- R6: A start strobe in the middle of a cell abandons that cell: its words not yet accepted produce no output, and the new cell is handled normally.
- R7: A transmit cell leaves on the line one edge after each word is accepted, with `line_soc_o` on word 0. Word 1 bits [31:24] are replaced by the HEC of transmit word 0 (computed as in R2) and all other bits are unchanged.
- R8: `rx_rdy_o` equals `app_rdy_i & byp_rdy_i` and `tx_rdy_o` equals `line_rdy_i`, both as sampled at the previous edge. A low ready never suppresses or delays output words.
- R9: Transmit words with `tx_vld_i` high and `tx_soc_i` low while no transmit cell is open produce no line output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rx_vld_i | input | 1 | Receive word valid |
| rx_soc_i | input | 1 | Receive start of cell (word 0) |
| rx_data_i | input | 32 | Receive word |
| rx_rdy_o | output | 1 | Ready passed back to the receive source |
| cfg_vc_i | input | 24 | Connection identifier routed to the application |
| app_vld_o | output | 1 | Application port word valid |
| app_soc_o | output | 1 | Application port start of cell |
| app_data_o | output | 32 | Application port word |
| app_rdy_i | input | 1 | Application ready |
| byp_vld_o | output | 1 | Bypass port word valid |
| byp_soc_o | output | 1 | Bypass port start of cell |
| byp_data_o | output | 32 | Bypass port word |
| byp_rdy_i | input | 1 | Bypass ready |
| tx_vld_i | input | 1 | Transmit word valid |
| tx_soc_i | input | 1 | Transmit start of cell |
| tx_data_i | input | 32 | Transmit word |
| tx_rdy_o | output | 1 | Ready passed back to the transmit source |
| line_vld_o | output | 1 | Line word valid |
| line_soc_o | output | 1 | Line start of cell |
| line_data_o | output | 32 | Line word with regenerated HEC |
| line_rdy_i | input | 1 | Line ready |

## Verification
Two things can land in the same cycle on a port. One is the release of the held header word of a new cell. The other is the emission of the last word of the previous cell. The bench provokes this by sending receive cells back to back with no idle cycle, and by sending a start strobe partway through a cell. It also runs a transmit cell in the very cycles in which a bad-HEC receive cell is being dropped. A behavioural model in the bench predicts every output on every clock, and any mismatch in timing, routing or data is flagged.

// File: rtl/atm_hec_pkg.sv
package atm_hec_pkg;

    localparam int WORD_W = 32;

    typedef struct packed {
        logic              vld;
        logic              soc;
        logic [WORD_W-1:0] data;
    } word_t;

    // CRC-8, generator x^8+x^2+x+1, zero start, bit-serial MSB first, coset 0x55
    function automatic logic [7:0] hec_calc(input logic [WORD_W-1:0] hdr);
        logic [7:0] crc;
        logic       fb;
        crc = 8'h00;
        for (int i = WORD_W - 1; i >= 0; i--) begin
            fb  = crc[7] ^ hdr[i];
            crc = {crc[6:0], 1'b0} ^ (fb ? 8'h07 : 8'h00);
        end
        return crc ^ 8'h55;
    endfunction

endpackage

// File: rtl/atm_rx_check.sv
module atm_rx_check
    import atm_hec_pkg::*;
#(
    parameter int CELL_WORDS = 14,
    parameter int VC_LSB     = 4,
    parameter int VC_W       = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_vld,
    input  logic              in_soc,
    input  logic [WORD_W-1:0] in_data,
    input  logic [VC_W-1:0]   vc_match,
    output word_t             app_word,
    output word_t             byp_word
);

    localparam int              IDX_W    = $clog2(CELL_WORDS);
    localparam logic [IDX_W-1:0] HEC_IDX = IDX_W'(1);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CELL_WORDS - 1);

    typedef struct packed {
        logic              open;
        logic [IDX_W-1:0]  idx;
        logic [WORD_W-1:0] hdr;
        logic              pass;
        logic              to_app;
        logic              stg_vld;
        logic [WORD_W-1:0] stg_data;
        word_t             app;
        word_t             byp;
    } rx_state_t;

    rx_state_t st_q, st_d;

    logic hec_ok;
    logic vc_hit;
    logic keep;

    assign hec_ok = (hec_calc(st_q.hdr) == in_data[WORD_W-1:WORD_W-8]);
    assign vc_hit = (st_q.hdr[VC_LSB +: VC_W] == vc_match);

    always_comb begin
        st_d         = st_q;
        st_d.app     = '0;
        st_d.byp     = '0;
        st_d.stg_vld = 1'b0;
        keep         = st_q.pass;

        // staged payload/HEC word from the previous accepted beat
        if (st_q.stg_vld) begin
            if (st_q.to_app) begin
                st_d.app = '{vld: 1'b1, soc: 1'b0, data: st_q.stg_data};
            end else begin
                st_d.byp = '{vld: 1'b1, soc: 1'b0, data: st_q.stg_data};
            end
        end

        if (in_vld) begin
            if (in_soc) begin
                st_d.open = 1'b1;
                st_d.idx  = HEC_IDX;
                st_d.hdr  = in_data;
                st_d.pass = 1'b0;
            end else if (st_q.open) begin
                if (st_q.idx == HEC_IDX) begin
                    keep          = hec_ok;
                    st_d.pass     = hec_ok;
                    st_d.to_app   = vc_hit;
                    if (hec_ok) begin
                        if (vc_hit) begin
                            st_d.app = '{vld: 1'b1, soc: 1'b1, data: st_q.hdr};
                        end else begin
                            st_d.byp = '{vld: 1'b1, soc: 1'b1, data: st_q.hdr};
                        end
                    end
                end
                st_d.stg_vld  = keep;
                st_d.stg_data = in_data;
                if (st_q.idx == LAST_IDX) begin
                    st_d.open = 1'b0;
                    st_d.idx  = '0;
                end else begin
                    st_d.idx  = st_q.idx + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign app_word = st_q.app;
    assign byp_word = st_q.byp;

    AST_SINGLE_DEST: assert property (@(posedge clk) disable iff (!rst_n)
        !(app_word.vld && byp_word.vld)); // R3

    AST_SOC_HAS_VLD: assert property (@(posedge clk) disable iff (!rst_n)
        (app_word.soc || byp_word.soc) |-> (app_word.vld || byp_word.vld)); // R4

    AST_BAD_HEC_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && !in_soc && st_q.open && st_q.idx == HEC_IDX && !hec_ok)
        |=> (!app_word.vld && !byp_word.vld)); // R2

    AST_STRAY_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && !in_soc && !st_q.open && !st_q.stg_vld)
        |=> (!app_word.vld && !byp_word.vld)); // R5

endmodule

// File: rtl/atm_tx_regen.sv
module atm_tx_regen
    import atm_hec_pkg::*;
#(
    parameter int CELL_WORDS = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_vld,
    input  logic              in_soc,
    input  logic [WORD_W-1:0] in_data,
    output word_t             line_word
);

    localparam int               IDX_W    = $clog2(CELL_WORDS);
    localparam logic [IDX_W-1:0] HEC_IDX  = IDX_W'(1);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CELL_WORDS - 1);

    typedef struct packed {
        logic              open;
        logic [IDX_W-1:0]  idx;
        logic [WORD_W-1:0] hdr;
        word_t             out;
    } tx_state_t;

    tx_state_t st_q, st_d;

    always_comb begin
        st_d     = st_q;
        st_d.out = '0;
        if (in_vld) begin
            if (in_soc) begin
                st_d.open = 1'b1;
                st_d.idx  = HEC_IDX;
                st_d.hdr  = in_data;
                st_d.out  = '{vld: 1'b1, soc: 1'b1, data: in_data};
            end else if (st_q.open) begin
                st_d.out.vld  = 1'b1;
                st_d.out.data = in_data;
                if (st_q.idx == HEC_IDX) begin
                    st_d.out.data[WORD_W-1:WORD_W-8] = hec_calc(st_q.hdr);
                end
                if (st_q.idx == LAST_IDX) begin
                    st_d.open = 1'b0;
                    st_d.idx  = '0;
                end else begin
                    st_d.idx  = st_q.idx + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign line_word = st_q.out;

    AST_TX_HEC_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(line_word.soc) && line_word.vld && !line_word.soc)
        |-> (line_word.data[WORD_W-1:WORD_W-8] == hec_calc($past(line_word.data)))); // R7

    AST_TX_STRAY: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && !in_soc && !st_q.open) |=> !line_word.vld); // R9

endmodule

// File: rtl/atm_cell_hec_engine.sv
module atm_cell_hec_engine
    import atm_hec_pkg::*;
#(
    parameter int CELL_WORDS = 14,
    parameter int VC_LSB     = 4,
    parameter int VC_W       = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_vld_i,
    input  logic              rx_soc_i,
    input  logic [WORD_W-1:0] rx_data_i,
    output logic              rx_rdy_o,
    input  logic [VC_W-1:0]   cfg_vc_i,
    output logic              app_vld_o,
    output logic              app_soc_o,
    output logic [WORD_W-1:0] app_data_o,
    input  logic              app_rdy_i,
    output logic              byp_vld_o,
    output logic              byp_soc_o,
    output logic [WORD_W-1:0] byp_data_o,
    input  logic              byp_rdy_i,
    input  logic              tx_vld_i,
    input  logic              tx_soc_i,
    input  logic [WORD_W-1:0] tx_data_i,
    output logic              tx_rdy_o,
    output logic              line_vld_o,
    output logic              line_soc_o,
    output logic [WORD_W-1:0] line_data_o,
    input  logic              line_rdy_i
);

    typedef struct packed {
        logic rx_rdy;
        logic tx_rdy;
    } rdy_state_t;

    rdy_state_t rdy_q, rdy_d;
    word_t      app_w, byp_w, line_w;

    atm_rx_check #(
        .CELL_WORDS (CELL_WORDS),
        .VC_LSB     (VC_LSB),
        .VC_W       (VC_W)
    ) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_vld   (rx_vld_i),
        .in_soc   (rx_soc_i),
        .in_data  (rx_data_i),
        .vc_match (cfg_vc_i),
        .app_word (app_w),
        .byp_word (byp_w)
    );

    atm_tx_regen #(
        .CELL_WORDS (CELL_WORDS)
    ) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_vld    (tx_vld_i),
        .in_soc    (tx_soc_i),
        .in_data   (tx_data_i),
        .line_word (line_w)
    );

    always_comb begin
        rdy_d        = rdy_q;
        rdy_d.rx_rdy = app_rdy_i & byp_rdy_i;
        rdy_d.tx_rdy = line_rdy_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdy_q <= '0;
        end else begin
            rdy_q <= rdy_d;
        end
    end

    assign rx_rdy_o    = rdy_q.rx_rdy;
    assign tx_rdy_o    = rdy_q.tx_rdy;
    assign app_vld_o   = app_w.vld;
    assign app_soc_o   = app_w.soc;
    assign app_data_o  = app_w.data;
    assign byp_vld_o   = byp_w.vld;
    assign byp_soc_o   = byp_w.soc;
    assign byp_data_o  = byp_w.data;
    assign line_vld_o  = line_w.vld;
    assign line_soc_o  = line_w.soc;
    assign line_data_o = line_w.data;

    AST_RX_RDY_RELAY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (rx_rdy_o == $past(app_rdy_i && byp_rdy_i))); // R8

    AST_TX_RDY_RELAY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (tx_rdy_o == $past(line_rdy_i))); // R8

endmodule

// File: tb/atm_cell_hec_engine_bench.sv
module atm_cell_hec_engine_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_vld = 1'b0, rx_soc = 1'b0;
    logic [31:0] rx_data = '0;
    logic [23:0] cfg_vc = 24'h012345;
    logic        app_rdy = 1'b1, byp_rdy = 1'b1, line_rdy = 1'b1;
    logic        tx_vld = 1'b0, tx_soc = 1'b0;
    logic [31:0] tx_data = '0;
    logic        rx_rdy, tx_rdy;
    logic        app_vld, app_soc, byp_vld, byp_soc, line_vld, line_soc;
    logic [31:0] app_data, byp_data, line_data;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    bit started = 0;

    always #10 clk = ~clk;

    atm_cell_hec_engine u_atm_cell_hec_engine (
        .clk(clk), .rst_n(rst_n),
        .rx_vld_i(rx_vld), .rx_soc_i(rx_soc), .rx_data_i(rx_data), .rx_rdy_o(rx_rdy),
        .cfg_vc_i(cfg_vc),
        .app_vld_o(app_vld), .app_soc_o(app_soc), .app_data_o(app_data), .app_rdy_i(app_rdy),
        .byp_vld_o(byp_vld), .byp_soc_o(byp_soc), .byp_data_o(byp_data), .byp_rdy_i(byp_rdy),
        .tx_vld_i(tx_vld), .tx_soc_i(tx_soc), .tx_data_i(tx_data), .tx_rdy_o(tx_rdy),
        .line_vld_o(line_vld), .line_soc_o(line_soc), .line_data_o(line_data), .line_rdy_i(line_rdy)
    );

    function automatic logic [7:0] ref_hec(input logic [31:0] h);
        logic [7:0] c = 8'h00;
        for (int b = 3; b >= 0; b--) begin
            c = c ^ h[b*8 +: 8];
            for (int k = 0; k < 8; k++) c = c[7] ? ((c << 1) ^ 8'h07) : (c << 1);
        end
        return c ^ 8'h55;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int          m_idx = 0, t_idx = 0;
    logic [31:0] m_hdr, t_hdr, st_data;
    bit          m_pass, m_app, st_vld, st_app;
    bit          e_app_vld, e_app_soc, e_byp_vld, e_byp_soc, e_line_vld, e_line_soc, e_rx_rdy, e_tx_rdy;
    logic [31:0] e_app_data, e_byp_data, e_line_data;

    always @(posedge clk) begin
        e_app_vld = 0; e_app_soc = 0; e_byp_vld = 0; e_byp_soc = 0;
        e_line_vld = 0; e_line_soc = 0;
        if (!rst_n) begin
            m_idx = 0; t_idx = 0; st_vld = 0; e_rx_rdy = 0; e_tx_rdy = 0;
        end else begin
            started = 1;
            if (st_vld) begin
                if (st_app) begin e_app_vld = 1; e_app_data = st_data; end
                else begin e_byp_vld = 1; e_byp_data = st_data; end
            end
            st_vld = 0;
            if (rx_vld) begin
                if (rx_soc) begin
                    m_idx = 1; m_hdr = rx_data;
                end else if (m_idx > 0) begin
                    if (m_idx == 1) begin
                        m_pass = (ref_hec(m_hdr) == rx_data[31:24]);
                        m_app  = (m_hdr[27:4] == cfg_vc);
                        if (m_pass && m_app) begin e_app_vld = 1; e_app_soc = 1; e_app_data = m_hdr; end
                        if (m_pass && !m_app) begin e_byp_vld = 1; e_byp_soc = 1; e_byp_data = m_hdr; end
                    end
                    if (m_pass) begin st_vld = 1; st_data = rx_data; st_app = m_app; end
                    m_idx++;
                    if (m_idx == 14) m_idx = 0;
                end
            end
            if (tx_vld) begin
                if (tx_soc) begin
                    t_idx = 1; t_hdr = tx_data;
                    e_line_vld = 1; e_line_soc = 1; e_line_data = tx_data;
                end else if (t_idx > 0) begin
                    e_line_vld = 1;
                    e_line_data = (t_idx == 1) ? {ref_hec(t_hdr), tx_data[23:0]} : tx_data;
                    t_idx++;
                    if (t_idx == 14) t_idx = 0;
                end
            end
            e_rx_rdy = app_rdy & byp_rdy;
            e_tx_rdy = line_rdy;
        end
    end

    // ---------------- per-cycle comparison and counters ----------------
    int          app_words = 0, byp_words = 0, app_cells = 0, byp_cells = 0;
    int          line_words = 0, line_cells = 0;
    logic [31:0] l_w0, l_w1;
    bit          l_prev_soc = 0;

    always @(negedge clk) begin
        if (started) begin
            chk(app_vld == e_app_vld, "R2/R3/R5/R6 app valid", 32'(app_vld), 32'(e_app_vld));
            chk(byp_vld == e_byp_vld, "R2/R3/R5/R6 bypass valid", 32'(byp_vld), 32'(e_byp_vld));
            if (e_app_vld) begin
                chk(app_soc == e_app_soc, "R4 app start", 32'(app_soc), 32'(e_app_soc));
                chk(app_data == e_app_data, "R4 app data", app_data, e_app_data);
            end
            if (e_byp_vld) begin
                chk(byp_soc == e_byp_soc, "R4 bypass start", 32'(byp_soc), 32'(e_byp_soc));
                chk(byp_data == e_byp_data, "R4 bypass data", byp_data, e_byp_data);
            end
            chk(line_vld == e_line_vld, "R7/R9 line valid", 32'(line_vld), 32'(e_line_vld));
            if (e_line_vld) begin
                chk(line_soc == e_line_soc, "R7 line start", 32'(line_soc), 32'(e_line_soc));
                chk(line_data == e_line_data, "R7 line data", line_data, e_line_data);
            end
            chk(rx_rdy == e_rx_rdy, "R8 rx ready", 32'(rx_rdy), 32'(e_rx_rdy));
            chk(tx_rdy == e_tx_rdy, "R8 tx ready", 32'(tx_rdy), 32'(e_tx_rdy));
        end
        if (app_vld) app_words++;
        if (app_vld && app_soc) app_cells++;
        if (byp_vld) byp_words++;
        if (byp_vld && byp_soc) byp_cells++;
        if (line_vld) line_words++;
        if (line_vld && line_soc) begin line_cells++; l_w0 = line_data; end
        if (line_vld && !line_soc && l_prev_soc) l_w1 = line_data;
        l_prev_soc = line_vld && line_soc;
    end

    // ---------------- stimulus tasks ----------------
    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); rx_vld = 0; rx_soc = 0; tx_vld = 0; tx_soc = 0;
        end
    endtask

    task automatic rx_cell(input logic [31:0] w0, input bit good, input int nwords, input int gap);
        for (int k = 0; k < nwords; k++) begin
            @(negedge clk);
            rx_vld = 1; rx_soc = (k == 0);
            if (k == 0) rx_data = w0;
            else if (k == 1) rx_data = {good ? ref_hec(w0) : (ref_hec(w0) ^ 8'h01), 24'hA5C3E1};
            else rx_data = {w0[15:0], 8'(k), 8'h3C};
            for (int g = 0; g < gap && k < nwords - 1; g++) begin
                @(negedge clk); rx_vld = 0; rx_soc = 0;
            end
        end
    endtask

    task automatic rx_loose(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk); rx_vld = 1; rx_soc = 0; rx_data = 32'hDEAD0000 + k;
        end
    endtask

    task automatic tx_cell(input logic [31:0] w0);
        for (int k = 0; k < 14; k++) begin
            @(negedge clk);
            tx_vld = 1; tx_soc = (k == 0);
            tx_data = (k == 0) ? w0 : (k == 1) ? 32'hEE123456 : {16'hBEEF, 8'(k), 8'h00};
        end
    endtask

    task automatic tx_loose(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk); tx_vld = 1; tx_soc = 0; tx_data = 32'h0BAD0000 + k;
        end
    endtask

    localparam logic [31:0] HDR_HIT  = 32'h00123450;
    localparam logic [31:0] HDR_MISS = 32'h00ABCDE2;

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int a0, b0, l0;
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(!app_vld && !byp_vld && !line_vld, "R1 valids in reset", {29'd0, app_vld, byp_vld, line_vld}, 0);
        chk(!rx_rdy && !tx_rdy, "R1 readies in reset", {30'd0, rx_rdy, tx_rdy}, 0);
        chk(ref_hec(32'h0) == 8'h55, "R2 HEC of zero header", 32'(ref_hec(32'h0)), 32'h55);
        rst_n = 1;
        idle(3);

        // R3: good cell, identifier hit -> application
        a0 = app_cells; b0 = byp_cells;
        rx_cell(HDR_HIT, 1, 14, 0); idle(3);
        chk(app_cells == a0 + 1 && byp_cells == b0, "R3 hit goes to application", app_cells - a0, 1);

        // R3: identifier miss -> bypass, with gaps between words (R4 timing)
        a0 = app_words; b0 = byp_words;
        rx_cell(HDR_MISS, 1, 14, 2); idle(3);
        chk(byp_words == b0 + 14 && app_words == a0, "R3/R4 miss goes to bypass", byp_words - b0, 14);

        // R2: bad HEC dropped, while a transmit cell runs in the same cycles (R7)
        a0 = app_words; b0 = byp_words; l0 = line_cells;
        fork
            rx_cell(HDR_HIT, 0, 14, 0);
            tx_cell(32'h0FF00F0A);
        join
        idle(3);
        chk(app_words == a0 && byp_words == b0, "R2 bad HEC cell dropped", app_words + byp_words - a0 - b0, 0);
        chk(line_cells == l0 + 1, "R7 transmit cell emitted", line_cells - l0, 1);
        chk(l_w1[31:24] == ref_hec(l_w0), "R7 regenerated HEC", 32'(l_w1[31:24]), 32'(ref_hec(l_w0)));
        chk(l_w1[23:0] == 24'h123456, "R7 low bits kept", 32'(l_w1[23:0]), 32'h123456);

        // R4: back-to-back cells, then a trailing loose word (R5)
        a0 = app_words; b0 = byp_words;
        rx_cell(HDR_HIT, 1, 14, 0);
        rx_cell(HDR_MISS, 1, 14, 0);
        rx_loose(1);
        idle(3);
        chk(app_words == a0 + 14 && byp_words == b0 + 14, "R4/R5 back-to-back cells", app_words + byp_words - a0 - b0, 28);

        // R5: loose words with no open cell
        a0 = app_words; b0 = byp_words;
        rx_loose(4); idle(3);
        chk(app_words == a0 && byp_words == b0, "R5 loose words ignored", app_words + byp_words - a0 - b0, 0);

        // R6: start strobe mid-cell
        a0 = app_words;
        rx_cell(HDR_HIT, 1, 5, 0);
        rx_cell(HDR_HIT, 1, 14, 0);
        idle(3);
        chk(app_words == a0 + 19, "R6 interrupted cell cut short", app_words - a0, 19);

        // R9: loose transmit words
        l0 = line_words;
        tx_loose(3); idle(3);
        chk(line_words == l0, "R9 loose transmit words ignored", line_words - l0, 0);

        // R8: ready relay and no gating
        @(negedge clk); app_rdy = 0; line_rdy = 0;
        @(negedge clk);
        chk(rx_rdy == 0 && tx_rdy == 0, "R8 readies fall", {30'd0, rx_rdy, tx_rdy}, 0);
        a0 = app_words; l0 = line_words;
        fork
            rx_cell(HDR_HIT, 1, 14, 0);
            tx_cell(32'h12345678);
        join
        idle(3);
        chk(app_words == a0 + 14 && line_words == l0 + 14, "R8 low ready does not stall", app_words + line_words - a0 - l0, 28);
        @(negedge clk); app_rdy = 1; byp_rdy = 1; line_rdy = 1;
        @(negedge clk);
        chk(rx_rdy == 1 && tx_rdy == 1, "R8 readies rise", {30'd0, rx_rdy, tx_rdy}, 3);

        // R1: reset mid-cell clears outputs
        rx_cell(HDR_HIT, 1, 6, 0);
        @(negedge clk); rx_vld = 0; rst_n = 0;
        @(negedge clk);
        chk(!app_vld && !byp_vld && !rx_rdy, "R1 reset mid-cell", {29'd0, app_vld, byp_vld, rx_rdy}, 0);
        rst_n = 1;
        rx_loose(3); idle(3);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule